// File: doc/BRIEF.md
# Memory Access Port Bridge

This block sits behind a debug port and turns its access-port register requests into single 32-bit transfers on a simple system bus. Each request carries an access-port number, a 4-bit bank field, the two register-select bits from the access scan, a read/write flag and 32 bits of write data. The bridge builds an 8-bit register offset from the bank field and the select bits. It then serves one of four registers: a transfer address register, a data register, a control/status word and a constant identification word.

A read or write of the data register does not complete at once. It starts one bus transfer at the address held in the transfer address register. The bridge holds `busy` high until the bus handshake finishes, and the debug port answers WAIT to the host during that time. A read result is returned as the posted access-port read data. A bus error gives a fault response and sets a sticky bit that software clears by writing a one to it. Only the bridge whose configured number matches the request's access-port number responds to a request.

Top module: `memap_bridge`

## Requirements
- R1: After reset, `busy`, `rsp_done` and `bus_valid` are low, and the transfer address register and the control/status word both read as zero.
- R2: The register offset is {bank[3:0], sel[1:0], 2'b00}. The transfer address register is at offset 0x04 and holds a full 32-bit value that reads back unchanged.
- R3: A request whose access-port number differs from the parameter `AP_NUM` completes with `rsp_error` low and read data zero. It changes no register and starts no bus transfer.
- R4: The identification register at offset 0xFC reads as the parameter `ID_VALUE`. A write to it changes nothing.
- R5: A write to the data register (offset 0x0C) while transfers are enabled drives `bus_valid` with `bus_we`=1, `bus_addr` equal to the transfer address and `bus_wdata` equal to the request data. All of these stay stable until `bus_ready`.
- R6: A read of the data register while transfers are enabled drives a bus transfer with `bus_we`=0. The response returns `bus_rdata` as sampled at the handshake.
- R7: `busy` is high from the cycle after a data-register request is accepted until the cycle in which the handshake completes. Requests presented while `busy` is high are dropped: they get no response and have no effect.
- R8: A handshake with `bus_err` high gives a response with `rsp_error` high and sets control/status bit 0. That bit stays set until a control/status write with bit 0 equal to 1.
- R9: Control/status bit 4 enables transfers and resets to 0. A data-register access while it is 0 completes with `rsp_error` high and makes no bus transfer. It does not set the sticky bit.
- R10: A request to any register other than the data register completes with `rsp_done` one cycle after it is sampled. A bus transfer completes one cycle after its handshake. Write responses carry read data zero.
- R11: Offsets inside the matching access port that map to no register read as zero with `rsp_error` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when `busy` is low |
| req_apnum | input | 8 | Access-port number of the request |
| req_bank | input | 4 | Bank field, register offset bits [7:4] |
| req_sel | input | 2 | Register select, register offset bits [3:2] |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Bus transfer in progress |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_error | output | 1 | Fault response |
| rsp_rdata | output | 32 | Read data of the response |
| bus_valid | output | 1 | Bus transfer request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_ready | input | 1 | Bus transfer complete |
| bus_rdata | input | 32 | Bus read data |
| bus_err | input | 1 | Bus transfer error |

## Verification
The bench builds the bridge with `AP_NUM` set to 3 and a non-default `ID_VALUE`. With these values a request addressed to access port 0 becomes a foreign request, so the mismatch path is exercised, and the identification read is shown to come from the parameter. The bus model inserts a programmable number of wait cycles, which holds `busy` high long enough to drop an extra request and to check that the address and data stay stable. Addresses whose top nibble is 0xE return a bus error, which drives the sticky-bit path.

// File: rtl/memap_pkg.sv
package memap_pkg;

  localparam int APNUM_W = 8;
  localparam int BANK_W  = 4;
  localparam int SEL_W   = 2;
  localparam int OFS_W   = BANK_W + SEL_W + 2;

  localparam logic [OFS_W-1:0] OFS_CSW = 8'h00;
  localparam logic [OFS_W-1:0] OFS_TAR = 8'h04;
  localparam logic [OFS_W-1:0] OFS_DRW = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_IDR = 8'hFC;

  localparam int CSW_ERR_BIT = 0;
  localparam int CSW_EN_BIT  = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } xfer_state_e;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_CSW,
    RS_TAR,
    RS_DRW,
    RS_IDR
  } reg_sel_e;

endpackage

// File: rtl/memap_decode.sv
module memap_decode
  import memap_pkg::*;
#(
  parameter logic [APNUM_W-1:0] AP_NUM = '0
) (
  input  logic [APNUM_W-1:0] req_apnum,
  input  logic [BANK_W-1:0]  req_bank,
  input  logic [SEL_W-1:0]   req_sel,
  output logic               ap_hit,
  output reg_sel_e           sel
);

  logic [OFS_W-1:0] ofs;

  always_comb begin
    ofs    = {req_bank, req_sel, 2'b00};
    ap_hit = (req_apnum == AP_NUM);
    sel    = RS_NONE;
    if (ap_hit) begin
      case (ofs)
        OFS_CSW: sel = RS_CSW;
        OFS_TAR: sel = RS_TAR;
        OFS_DRW: sel = RS_DRW;
        OFS_IDR: sel = RS_IDR;
        default: sel = RS_NONE;
      endcase
    end
  end

endmodule

// File: rtl/memap_regs.sv
module memap_regs
  import memap_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              err_set,
  output logic [ADDR_W-1:0] tar,
  output logic              xfer_en,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] tar_q, tar_d;
  logic              en_q, en_d;
  logic              err_q, err_d;
  logic              upd;

  always_comb begin
    tar_d = tar_q;
    en_d  = en_q;
    err_d = err_q;
    upd   = wr_en | err_set;
    if (wr_en) begin
      case (sel)
        RS_TAR: tar_d = wdata[ADDR_W-1:0];
        RS_CSW: begin
          en_d = wdata[CSW_EN_BIT];
          if (wdata[CSW_ERR_BIT]) err_d = 1'b0;
        end
        default: ;
      endcase
    end
    if (err_set) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tar_q <= '0;
      en_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (upd) begin
      tar_q <= tar_d;
      en_q  <= en_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (sel)
      RS_CSW: begin
        rd_data[CSW_EN_BIT]  = en_q;
        rd_data[CSW_ERR_BIT] = err_q;
      end
      RS_TAR:  rd_data = DATA_W'(tar_q);
      RS_IDR:  rd_data = ID_VALUE;
      default: rd_data = '0;
    endcase
  end

  assign tar     = tar_q;
  assign xfer_en = en_q;

endmodule

// File: rtl/memap_bus_fsm.sv
module memap_bus_fsm
  import memap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_we,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic [DATA_W-1:0] launch_wdata,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err,
  output logic              busy,
  output logic              done,
  output logic              done_err,
  output logic [DATA_W-1:0] done_rdata
);

  xfer_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;

  always_comb begin
    state_d = state_q;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: if (launch) state_d = ST_XFER;
      ST_XFER: if (bus_ready) begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (launch) begin
      addr_q  <= launch_addr;
      wdata_q <= launch_wdata;
      we_q    <= launch_we;
    end
  end

  assign bus_valid  = (state_q == ST_XFER);
  assign busy       = (state_q != ST_IDLE);
  assign bus_we     = we_q;
  assign bus_addr   = addr_q;
  assign bus_wdata  = wdata_q;
  assign done_err   = bus_err;
  assign done_rdata = we_q ? '0 : bus_rdata;

endmodule

// File: rtl/memap_bridge.sv
module memap_bridge
  import memap_pkg::*;
#(
  parameter int                 ADDR_W   = 32,
  parameter int                 DATA_W   = 32,
  parameter logic [APNUM_W-1:0] AP_NUM   = 8'h00,
  parameter logic [DATA_W-1:0]  ID_VALUE = 32'h1C57_0A01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [7:0]        req_apnum,
  input  logic [3:0]        req_bank,
  input  logic [1:0]        req_sel,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_done,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err
);

  logic              ap_hit;
  reg_sel_e          sel;
  logic              accept;
  logic              launch;
  logic              drw_blocked;
  logic [ADDR_W-1:0] tar;
  logic              xfer_en;
  logic [DATA_W-1:0] reg_rdata;
  logic              fsm_done, fsm_err;
  logic [DATA_W-1:0] fsm_rdata;

  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  memap_decode #(.AP_NUM(AP_NUM)) u_decode (
    .req_apnum (req_apnum),
    .req_bank  (req_bank),
    .req_sel   (req_sel),
    .ap_hit    (ap_hit),
    .sel       (sel)
  );

  assign accept      = req_valid & ~busy;
  assign launch      = accept & (sel == RS_DRW) & xfer_en;
  assign drw_blocked = (sel == RS_DRW) & ~xfer_en;

  memap_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ID_VALUE (ID_VALUE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept & req_wr),
    .sel     (sel),
    .wdata   (req_wdata),
    .err_set (fsm_done & fsm_err),
    .tar     (tar),
    .xfer_en (xfer_en),
    .rd_data (reg_rdata)
  );

  memap_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .launch_we    (req_wr),
    .launch_addr  (tar),
    .launch_wdata (req_wdata),
    .bus_valid    (bus_valid),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_ready    (bus_ready),
    .bus_rdata    (bus_rdata),
    .bus_err      (bus_err),
    .busy         (busy),
    .done         (fsm_done),
    .done_err     (fsm_err),
    .done_rdata   (fsm_rdata)
  );

  always_comb begin
    done_d  = 1'b0;
    err_d   = 1'b0;
    rdata_d = '0;
    if (fsm_done) begin
      done_d  = 1'b1;
      err_d   = fsm_err;
      rdata_d = fsm_rdata;
    end else if (accept && !launch) begin
      done_d  = 1'b1;
      err_d   = drw_blocked;
      rdata_d = req_wr ? '0 : reg_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q  <= done_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_done  = done_q;
  assign rsp_error = err_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/memap_bridge_chk.sv
module memap_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              rsp_done,
  input logic              rsp_error,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ready,
  input logic              bus_err
);

  assert_hold_until_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));

  assert_launch_from_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> $past(req_valid));

  assert_resp_after_handshake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready) |=> rsp_done);

  assert_no_resp_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !bus_valid);

  assert_fault_on_bus_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_err) |=> rsp_error);

  assert_error_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> rsp_done);

endmodule

bind memap_bridge memap_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .rsp_done  (rsp_done),
  .rsp_error (rsp_error),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ready (bus_ready),
  .bus_err   (bus_err)
);

// File: tb/memap_bridge_test.sv
module memap_bridge_test;

  localparam logic [7:0]  MY_AP = 8'h03;
  localparam logic [31:0] MY_ID = 32'h5A31_0C07;

  logic        clk, rst_n;
  logic        req_valid, req_wr;
  logic [7:0]  req_apnum;
  logic [3:0]  req_bank;
  logic [1:0]  req_sel;
  logic [31:0] req_wdata;
  logic        busy, rsp_done, rsp_error;
  logic [31:0] rsp_rdata;
  logic        bus_valid, bus_we, bus_ready, bus_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  memap_bridge #(.AP_NUM(MY_AP), .ID_VALUE(MY_ID)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_apnum(req_apnum),
    .req_bank(req_bank), .req_sel(req_sel), .req_wr(req_wr), .req_wdata(req_wdata),
    .busy(busy), .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [31:0] rdata;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // bus model
  logic [31:0] mem [16];
  int          wait_cycles = 0;
  int          wcnt = 0;
  int          n_xfer = 0;
  bit          stable_bad = 0;
  logic [31:0] snap_addr, snap_wd, last_addr, last_wd;
  logic        snap_we, last_we;

  initial begin
    bus_ready = 1'b0;
    bus_err   = 1'b0;
    bus_rdata = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
  end

  always @(negedge clk) begin
    if (rst_n !== 1'b1 || bus_valid !== 1'b1) begin
      bus_ready <= 1'b0;
      bus_err   <= 1'b0;
      wcnt = 0;
    end else begin
      if (wcnt == 0) begin
        snap_addr = bus_addr; snap_wd = bus_wdata; snap_we = bus_we;
      end else if (bus_addr !== snap_addr || bus_wdata !== snap_wd || bus_we !== snap_we) begin
        stable_bad = 1;
      end
      if (wcnt >= wait_cycles) begin
        bus_ready <= 1'b1;
        bus_err   <= (bus_addr[31:28] == 4'hE);
        bus_rdata <= bus_we ? 32'h0 : mem[bus_addr[5:2]];
        if (bus_we && bus_addr[31:28] != 4'hE) mem[bus_addr[5:2]] = bus_wdata;
        n_xfer++;
        last_addr = bus_addr; last_wd = bus_wdata; last_we = bus_we;
      end else begin
        bus_ready <= 1'b0;
      end
      wcnt++;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (rst_n === 1'b1 && rsp_done === 1'b1) begin
      if (sb_q.size() == 0) begin
        chk(0, "R7", "unexpected response", rsp_rdata, 32'h0);
      end else begin
        e = sb_q.pop_front();
        chk(rsp_rdata === e.rdata, e.tag, "rdata", rsp_rdata, e.rdata);
        chk(rsp_error === e.err, e.tag, "error", {31'h0, rsp_error}, {31'h0, e.err});
      end
    end
  end

  // driver
  task automatic ap_req(input logic [7:0] apn, input logic [3:0] bank, input logic [1:0] sl,
                        input bit wr, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_apnum = apn; req_bank = bank; req_sel = sl;
    req_wr = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic push_exp(input logic [31:0] rd, input bit er, input string tag);
    exp_t e;
    e.rdata = rd; e.err = er; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic wait_idle();
    while (sb_q.size() != 0 || busy === 1'b1) @(negedge clk);
  endtask

  task automatic ap(input logic [7:0] apn, input logic [3:0] bank, input logic [1:0] sl,
                    input bit wr, input logic [31:0] wd,
                    input logic [31:0] erd, input bit eerr, input string tag);
    push_exp(erd, eerr, tag);
    ap_req(apn, bank, sl, wr, wd);
    wait_idle();
  endtask

  // register coordinates: CSW bank0 sel0, TAR bank0 sel1, DRW bank0 sel3, IDR bankF sel3
  int xf0;

  initial begin
    req_valid = 0; req_wr = 0; req_apnum = 0; req_bank = 0; req_sel = 0; req_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(busy === 1'b0, "R1", "busy after reset", {31'h0, busy}, 32'h0);
    chk(rsp_done === 1'b0, "R1", "rsp_done after reset", {31'h0, rsp_done}, 32'h0);
    chk(bus_valid === 1'b0, "R1", "bus_valid after reset", {31'h0, bus_valid}, 32'h0);
    ap(MY_AP, 4'h0, 2'd1, 0, 0, 32'h0, 0, "R1");
    ap(MY_AP, 4'h0, 2'd0, 0, 0, 32'h0, 0, "R1");

    // R2 / R10: TAR write, then read with latency check
    ap(MY_AP, 4'h0, 2'd1, 1, 32'h0000_0010, 32'h0, 0, "R10");
    push_exp(32'h0000_0010, 0, "R2");
    ap_req(MY_AP, 4'h0, 2'd1, 0, 0);
    chk(rsp_done === 1'b1, "R10", "register response one cycle after request", {31'h0, rsp_done}, 32'h1);
    wait_idle();
    ap(MY_AP, 4'h1, 2'd1, 0, 0, 32'h0, 0, "R11");
    ap(MY_AP, 4'h3, 2'd2, 0, 0, 32'h0, 0, "R11");

    // R4
    ap(MY_AP, 4'hF, 2'd3, 0, 0, MY_ID, 0, "R4");
    ap(MY_AP, 4'hF, 2'd3, 1, 32'hFFFF_FFFF, 32'h0, 0, "R4");
    ap(MY_AP, 4'hF, 2'd3, 0, 0, MY_ID, 0, "R4");

    // R3: foreign access port
    xf0 = n_xfer;
    ap(8'h00, 4'h0, 2'd1, 1, 32'hDEAD_BEEF, 32'h0, 0, "R3");
    ap(8'h00, 4'hF, 2'd3, 0, 0, 32'h0, 0, "R3");
    ap(MY_AP, 4'h0, 2'd1, 0, 0, 32'h0000_0010, 0, "R3");
    ap(8'h00, 4'h0, 2'd0, 1, 32'h0000_0010, 32'h0, 0, "R3");
    ap(MY_AP, 4'h0, 2'd0, 0, 0, 32'h0, 0, "R3");
    ap(8'h00, 4'h0, 2'd3, 0, 0, 32'h0, 0, "R3");
    chk(n_xfer == xf0, "R3", "bus transfers from foreign port", n_xfer, xf0);

    // R9: transfers disabled
    ap(MY_AP, 4'h0, 2'd3, 1, 32'h1111_2222, 32'h0, 1, "R9");
    chk(n_xfer == xf0, "R9", "bus transfers while disabled", n_xfer, xf0);
    ap(MY_AP, 4'h0, 2'd0, 0, 0, 32'h0, 0, "R9");
    ap(MY_AP, 4'h0, 2'd0, 1, 32'h0000_0010, 32'h0, 0, "R9");
    ap(MY_AP, 4'h0, 2'd0, 0, 0, 32'h0000_0010, 0, "R9");

    // R5: write with wait states
    wait_cycles = 3;
    stable_bad = 0;
    push_exp(32'h0, 0, "R5");
    ap_req(MY_AP, 4'h0, 2'd3, 1, 32'hA5A5_0001);
    chk(busy === 1'b1, "R7", "busy during transfer", {31'h0, busy}, 32'h1);
    chk(rsp_done === 1'b0, "R7", "no early response", {31'h0, rsp_done}, 32'h0);
    wait_idle();
    chk(last_addr === 32'h0000_0010, "R5", "bus_addr", last_addr, 32'h10);
    chk(last_we === 1'b1, "R5", "bus_we", {31'h0, last_we}, 32'h1);
    chk(last_wd === 32'hA5A5_0001, "R5", "bus_wdata", last_wd, 32'hA5A5_0001);
    chk(stable_bad == 0, "R5", "stable while waiting", {31'h0, stable_bad}, 32'h0);

    // R6: read back with no wait
    wait_cycles = 0;
    ap(MY_AP, 4'h0, 2'd3, 0, 0, 32'hA5A5_0001, 0, "R6");
    chk(last_we === 1'b0, "R6", "bus_we on read", {31'h0, last_we}, 32'h0);

    // R7: request during busy is dropped
    wait_cycles = 4;
    push_exp(32'hA5A5_0001, 0, "R6");
    ap_req(MY_AP, 4'h0, 2'd3, 0, 0);
    chk(busy === 1'b1, "R7", "busy after launch", {31'h0, busy}, 32'h1);
    ap_req(MY_AP, 4'h0, 2'd1, 1, 32'h1234_5678);
    wait_idle();
    repeat (2) @(negedge clk);
    ap(MY_AP, 4'h0, 2'd1, 0, 0, 32'h0000_0010, 0, "R7");

    // R8: bus error and sticky bit
    wait_cycles = 1;
    ap(MY_AP, 4'h0, 2'd1, 1, 32'hE000_0008, 32'h0, 0, "R8");
    ap(MY_AP, 4'h0, 2'd3, 1, 32'h0BAD_0BAD, 32'h0, 1, "R8");
    ap(MY_AP, 4'h0, 2'd0, 0, 0, 32'h0000_0011, 0, "R8");
    ap(MY_AP, 4'h0, 2'd1, 1, 32'h0000_0010, 32'h0, 0, "R8");
    ap(MY_AP, 4'h0, 2'd3, 0, 0, 32'hA5A5_0001, 0, "R8");
    ap(MY_AP, 4'h0, 2'd0, 0, 0, 32'h0000_0011, 0, "R8");
    ap(MY_AP, 4'h0, 2'd0, 1, 32'h0000_0010, 32'h0, 0, "R8");
    ap(MY_AP, 4'h0, 2'd0, 0, 0, 32'h0000_0011, 0, "R8");
    ap(MY_AP, 4'h0, 2'd0, 1, 32'h0000_0011, 32'h0, 0, "R8");
    ap(MY_AP, 4'h0, 2'd0, 0, 0, 32'h0000_0010, 0, "R8");

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R10", "all responses seen", sb_q.size(), 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (R7/R10 completion): actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule